// File: doc/BRIEF.md
# Open-Drain I2C Byte Master

This block is a byte-level master for a two-wire I2C bus whose pads can only pull a line low or let it go. The block never drives a high level. For each of the clock line (SCL) and the data line (SDA) it outputs only an output-enable, and the pad drives a constant 0 while that enable is set. When the enable is cleared, the external pull-up brings the line high. The bus level of SDA comes back on a single input, and the block samples it there.

A host issues one command at a time with a one-cycle request. The commands are: bus recovery (a train of clock pulses with SDA released), start condition, stop condition, byte write and byte read. Each command runs as a fixed sequence of bus phases. Each phase holds the line enables for `phaseLen + 1` system clocks, so one input sets the SCL rate. After a write the block reports the acknowledge bit it sampled and an error flag. After a read it presents the received byte. Multi-master arbitration and slave clock stretching are not handled.

Top module: `odi2c_master`

## Requirements
- R1: After reset, `busy`, `sclOe`, `sdaOe`, `ackBit`, `ackErr` and `rxByte` are all 0, so both lines are released.
- R2: Command code 1 (recovery) produces RECOVER_PULSES (10 by default) SCL low/high pulses in 2*RECOVER_PULSES phases. `sdaOe` stays 0 for the whole command, and the command ends with both lines released.
- R3: Command code 2 (start) runs 3 phases. The first phase releases both lines. The second phase pulls SDA low while SCL stays released. The third phase also pulls SCL low. The command ends with both enables set.
- R4: Command code 3 (stop) runs 3 phases. The first phase pulls both lines low. The second phase releases SCL. The third phase releases SDA, which makes a rising SDA edge while SCL is high. The command ends with both lines released.
- R5: Command code 4 (write) sends `txByte` MSB first. Each bit is set up while SCL is driven low and then clocked by one SCL pulse. SDA does not change while SCL is high. A 9th pulse samples SDA into `ackBit` (low means acknowledge). On acknowledge the command ends after 19 phases with SCL driven low and SDA released.
- R6: If the write's acknowledge sample is high, `ackErr` is set to 1 and a stop condition follows automatically (22 phases in total), leaving both lines released. On acknowledge `ackErr` is 0.
- R7: Command code 5 (read) samples SDA at the end of each of 8 SCL-high phases, MSB first, into `rxByte`. It then gives a 9th pulse with SDA released, which signals a not-acknowledge. It ends after 19 phases with SCL driven low and SDA released.
- R8: Every phase lasts `phaseLen + 1` clocks. `busy` therefore stays high for exactly (phases x (`phaseLen` + 1)) cycles after the accepting edge.
- R9: `busy` rises on the edge that accepts a command and falls when the last phase ends. A request made while `busy` is high is dropped, and it changes neither the running command nor `rxByte`.
- R10: A request with code 0, 6 or 7 while idle is ignored. `busy` stays 0 and neither line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle command request |
| cmdOp | input | 3 | Command code: 1 recovery, 2 start, 3 stop, 4 write, 5 read |
| txByte | input | DATA_W | Byte to send, captured when a command is accepted |
| phaseLen | input | DIV_W | Phase length minus one, in system clocks |
| sdaIn | input | 1 | Sampled SDA bus level |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A command is in progress |
| rxByte | output | DATA_W | Byte received by the last read |
| ackBit | output | 1 | SDA level sampled on the 9th clock of the last write |
| ackErr | output | 1 | The last write got no acknowledge |

## Verification
The bench builds the block with DIV_W = 2, DATA_W = 8 and RECOVER_PULSES = 10. The 2-bit phase input lets every phase length from 1 to 4 clocks be tried, so each command's busy length can be compared with phases x (phaseLen + 1). The 8-bit data width keeps every one of the 256 byte values affordable in both directions. Writes are done with a pattern of acknowledged and refused bytes, and reads use a behavioural slave that drives the byte back. A bus monitor counts SCL pulses, start and stop edges, and any SDA change during SCL high.

// File: rtl/odi2c_pkg.sv
package odi2c_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_RECOVER = 3'd1,
    OP_START   = 3'd2,
    OP_STOP    = 3'd3,
    OP_WRITE   = 3'd4,
    OP_READ    = 3'd5
  } opCode_e;

  typedef enum logic [1:0] {
    SDA_REL  = 2'd0,
    SDA_LOW  = 2'd1,
    SDA_DATA = 2'd2
  } sdaSel_e;

  typedef struct packed {
    logic    loadPhase;
    logic    sclLow;
    sdaSel_e sdaSel;
    logic    loadTx;
    logic    shiftTx;
    logic    sampleRx;
    logic    sampleAck;
    logic    clearErr;
  } ctrlStrobe_t;

endpackage

// File: rtl/odi2c_ctrl.sv
module odi2c_ctrl
  import odi2c_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int RECOVER_PULSES = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic        phaseEnd,
  input  logic        nackIn,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output opCode_e     activeOp
);

  localparam int BIT_PH  = 2 * DATA_W;
  localparam int RST_PH  = 2 * RECOVER_PULSES;
  localparam int TAIL_PH = BIT_PH + 6;
  localparam int MAX_PH  = (RST_PH > TAIL_PH) ? RST_PH : TAIL_PH;
  localparam int IDX_W   = $clog2(MAX_PH);

  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t K_ACKLO   = idx_t'(BIT_PH);
  localparam idx_t K_ACKHI   = idx_t'(BIT_PH + 1);
  localparam idx_t K_ACKEND  = idx_t'(BIT_PH + 2);
  localparam idx_t K_SP0     = idx_t'(BIT_PH + 3);
  localparam idx_t K_SP1     = idx_t'(BIT_PH + 4);
  localparam idx_t K_SP2     = idx_t'(BIT_PH + 5);
  localparam idx_t K_RSTLAST = idx_t'(RST_PH - 1);
  localparam idx_t K_TWO     = idx_t'(2);

  opCode_e op;
  idx_t    idx;
  opCode_e reqOp;
  logic    opKnown, accept, stepEnd, curLast, finish, advance;

  // SCL enable wanted during phase k of command op
  function automatic logic fSclLow(opCode_e o, idx_t k);
    case (o)
      OP_RECOVER: return ~k[0];
      OP_START:   return k == K_TWO;
      OP_STOP:    return k == '0;
      OP_WRITE, OP_READ: begin
        if (k < K_ACKLO) return ~k[0];
        return (k == K_ACKLO) || (k == K_ACKEND) || (k == K_SP0);
      end
      default:    return 1'b0;
    endcase
  endfunction

  function automatic sdaSel_e fSda(opCode_e o, idx_t k);
    case (o)
      OP_START: return (k == '0) ? SDA_REL : SDA_LOW;
      OP_STOP:  return (k == K_TWO) ? SDA_REL : SDA_LOW;
      OP_WRITE: begin
        if (k < K_ACKLO) return SDA_DATA;
        return ((k == K_SP0) || (k == K_SP1)) ? SDA_LOW : SDA_REL;
      end
      default:  return SDA_REL;
    endcase
  endfunction

  function automatic logic fLast(opCode_e o, idx_t k, logic nack);
    case (o)
      OP_RECOVER:        return k == K_RSTLAST;
      OP_START, OP_STOP: return k == K_TWO;
      OP_WRITE:          return ((k == K_ACKEND) && !nack) || (k == K_SP2);
      OP_READ:           return k == K_ACKEND;
      default:           return 1'b1;
    endcase
  endfunction

  always_comb begin
    reqOp   = opCode_e'(cmdOp);
    opKnown = (cmdOp >= 3'd1) && (cmdOp <= 3'd5);
    accept  = !busy && cmdValid && opKnown;
    stepEnd = busy && phaseEnd;
    curLast = fLast(op, idx, nackIn);
    finish  = stepEnd && curLast;
    advance = stepEnd && !curLast;

    strobe           = '0;
    strobe.loadPhase = accept || advance;
    strobe.loadTx    = accept;
    strobe.clearErr  = accept;
    if (accept) begin
      strobe.sclLow = fSclLow(reqOp, '0);
      strobe.sdaSel = fSda(reqOp, '0);
    end else begin
      strobe.sclLow = fSclLow(op, idx + 1'b1);
      strobe.sdaSel = fSda(op, idx + 1'b1);
    end
    strobe.shiftTx   = stepEnd && (op == OP_WRITE) && (idx < K_ACKLO) && idx[0];
    strobe.sampleRx  = stepEnd && (op == OP_READ) && (idx < K_ACKLO) && idx[0];
    strobe.sampleAck = stepEnd && (op == OP_WRITE) && (idx == K_ACKHI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      op   <= OP_NONE;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      op   <= reqOp;
      idx  <= '0;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (advance) begin
      idx <= idx + 1'b1;
    end
  end

  assign activeOp = op;

  // R9: a running command keeps its code until its last phase ends
  assert_op_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !finish) |=> (busy && $stable(op)));

  // R10: undefined codes never start a command
  assert_unknown_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && !opKnown) |=> !busy);

endmodule

// File: rtl/odi2c_dpath.sv
module odi2c_dpath
  import odi2c_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] txByte,
  input  logic [DIV_W-1:0]  phaseLen,
  input  logic              sdaIn,
  output logic              phaseEnd,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackBit,
  output logic              ackErr
);

  localparam int MSB = DATA_W - 1;

  logic [DIV_W-1:0]  timer;
  logic [DATA_W-1:0] txShift, rxShift;
  logic              dataBit, nextSdaOe;

  assign phaseEnd = (timer == '0);

  always_comb begin
    if (strobe.loadTx)       dataBit = txByte[MSB];
    else if (strobe.shiftTx) dataBit = txShift[MSB-1];
    else                     dataBit = txShift[MSB];
    case (strobe.sdaSel)
      SDA_LOW:  nextSdaOe = 1'b1;
      SDA_DATA: nextSdaOe = ~dataBit;
      default:  nextSdaOe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer   <= '0;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      ackBit  <= 1'b0;
      ackErr  <= 1'b0;
    end else begin
      if (strobe.loadPhase) begin
        timer <= phaseLen;
        sclOe <= strobe.sclLow;
        sdaOe <= nextSdaOe;
      end else if (timer != '0) begin
        timer <= timer - 1'b1;
      end
      if (strobe.loadTx)       txShift <= txByte;
      else if (strobe.shiftTx) txShift <= {txShift[MSB-1:0], 1'b0};
      if (strobe.sampleRx)     rxShift <= {rxShift[MSB-1:0], sdaIn};
      if (strobe.sampleAck) begin
        ackBit <= sdaIn;
        ackErr <= sdaIn;
      end else if (strobe.clearErr) begin
        ackErr <= 1'b0;
      end
    end
  end

  assign rxByte = rxShift;

  // R7: data and acknowledge are only sampled while SCL is released
  assert_sample_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleRx || strobe.sampleAck) |-> !sclOe);

  // R8: the controller never moves to a new phase before the timer runs out
  assert_phase_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    !phaseEnd |-> !strobe.loadPhase);

endmodule

// File: rtl/odi2c_master.sv
module odi2c_master
  import odi2c_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int DIV_W          = 8,
  parameter int RECOVER_PULSES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] txByte,
  input  logic [DIV_W-1:0]  phaseLen,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackBit,
  output logic              ackErr
);

  ctrlStrobe_t strobe;
  logic        phaseEnd;
  opCode_e     activeOp;

  odi2c_ctrl #(
    .DATA_W(DATA_W),
    .RECOVER_PULSES(RECOVER_PULSES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cmdValid(cmdValid),
    .cmdOp(cmdOp),
    .phaseEnd(phaseEnd),
    .nackIn(ackBit),
    .strobe(strobe),
    .busy(busy),
    .activeOp(activeOp)
  );

  odi2c_dpath #(
    .DATA_W(DATA_W),
    .DIV_W(DIV_W)
  ) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .txByte(txByte),
    .phaseLen(phaseLen),
    .sdaIn(sdaIn),
    .phaseEnd(phaseEnd),
    .sclOe(sclOe),
    .sdaOe(sdaOe),
    .rxByte(rxByte),
    .ackBit(ackBit),
    .ackErr(ackErr)
  );

  // R2: recovery never pulls SDA
  assert_recover_sda_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && activeOp == OP_RECOVER) |-> !sdaOe);

  // R5: write data holds steady across an SCL-high stretch
  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && activeOp == OP_WRITE && !ackErr && !sclOe && !$past(sclOe))
      |-> $stable(sdaOe));

  // R6: a refused write leaves the bus free
  assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && ackErr) |-> (!sclOe && !sdaOe));

  // R9: busy only starts in answer to a request
  assert_busy_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));

endmodule

// File: tb/sim_odi2c_master.sv
module sim_odi2c_master;

  localparam int DATA_W = 8;
  localparam int DIV_W  = 2;
  localparam int RPULSE = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [DATA_W-1:0] txByte = '0;
  logic [DIV_W-1:0] phaseLen = '0;
  logic slaveSda = 1'b1;
  logic sdaIn;
  logic sclOe, sdaOe, busy, ackBit, ackErr;
  logic [DATA_W-1:0] rxByte;

  assign sdaIn = ~sdaOe & slaveSda;

  odi2c_master #(.DATA_W(DATA_W), .DIV_W(DIV_W), .RECOVER_PULSES(RPULSE)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .txByte(txByte),
    .phaseLen(phaseLen), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy),
    .rxByte(rxByte), .ackBit(ackBit), .ackErr(ackErr)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // bus monitor and behavioural slave
  int riseCnt = 0, startCnt = 0, stopCnt = 0, glitchCnt = 0, sdaLowCnt = 0;
  int slaveMode = 0;            // 0 idle, 1 write-ack, 2 write-nack, 3 read
  logic [15:0] capShift = '0;
  logic [7:0] rdByte = '0;
  logic prevScl = 1'b1, prevSda = 1'b1;

  always @(negedge clk) begin : mon
    logic sclNow, sdaNow;
    sclNow = ~sclOe;
    sdaNow = ~sdaOe & slaveSda;
    if (sdaOe) sdaLowCnt++;
    if (sclNow && !prevScl) begin
      riseCnt++;
      capShift = {capShift[14:0], sdaNow};
    end
    if (sclNow && prevScl && prevSda && !sdaNow) startCnt++;
    if (sclNow && prevScl && !prevSda && sdaNow) stopCnt++;
    if (sclNow && prevScl && (sdaNow != prevSda) && slaveMode != 0 && riseCnt < 9) glitchCnt++;
    if (!sclNow && prevScl) begin
      if (slaveMode == 1 || slaveMode == 2)
        slaveSda = (riseCnt == 8) ? (slaveMode == 2) : 1'b1;
      else if (slaveMode == 3)
        slaveSda = (riseCnt < 8) ? rdByte[7 - riseCnt] : 1'b1;
    end
    prevScl = sclNow;
    prevSda = ~sdaOe & slaveSda;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCmd(input int op, input int data, input int len, input int mode,
                        input int rd, input bit inject, output int cycles);
    @(negedge clk);
    phaseLen  = len[DIV_W-1:0];
    slaveMode = mode;
    rdByte    = rd[7:0];
    slaveSda  = (mode == 3) ? rd[7] : 1'b1;
    riseCnt = 0; startCnt = 0; stopCnt = 0; glitchCnt = 0; sdaLowCnt = 0;
    capShift = '0;
    cmdOp    = op[2:0];
    txByte   = data[7:0];
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    cycles = 0;
    while (busy && cycles < 2000) begin
      cycles++;
      if (inject && cycles == 5) begin
        cmdValid = 1'b1;
        cmdOp    = 3'd5;
        txByte   = 8'h00;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
    end
    cmdValid = 1'b0;
  endtask

  function automatic int lines();
    return int'({sclOe, sdaOe});
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int cyc;
    int nack;
    logic [7:0] keepRx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 lines after reset", lines(), 0);
    check("R1 rxByte after reset", int'(rxByte), 0);
    check("R1 ack flags after reset", int'({ackBit, ackErr}), 0);

    // R2 recovery, every phase length
    for (int L = 0; L < 4; L++) begin
      runCmd(1, 0, L, 0, 0, 0, cyc);
      check("R8 recovery length", cyc, 2 * RPULSE * (L + 1));
      check("R2 recovery pulses", riseCnt, RPULSE);
      check("R2 sda never pulled", sdaLowCnt, 0);
      check("R2 lines released", lines(), 0);
    end

    // R3 start
    runCmd(2, 0, 1, 0, 0, 0, cyc);
    check("R8 start length", cyc, 3 * 2);
    check("R3 start edge seen", startCnt, 1);
    check("R3 lines after start", lines(), 3);

    // R5 / R6 every byte value, some refused
    for (int b = 0; b < 256; b++) begin
      nack = ((b % 7) == 3) ? 1 : 0;
      runCmd(4, b, 0, nack ? 2 : 1, 0, 0, cyc);
      check("R5 write length", cyc, nack ? 22 : 19);
      check("R5 write data", nack ? int'(capShift[9:2]) : int'(capShift[8:1]), b);
      check("R5 write pulses", riseCnt, nack ? 10 : 9);
      check("R5 sda steady while scl high", glitchCnt, 0);
      check("R5 ackBit", int'(ackBit), nack);
      check("R6 ackErr", int'(ackErr), nack);
      check("R6 automatic stop", stopCnt, nack);
      check("R6 lines after write", lines(), nack ? 0 : 2);
    end

    // R7 reads, every byte value, after a fresh start
    runCmd(2, 0, 0, 0, 0, 0, cyc);
    check("R3 repeated start", startCnt, 1);
    for (int b = 0; b < 256; b++) begin
      runCmd(5, 0, 0, 3, b, 0, cyc);
      check("R7 read length", cyc, 19);
      check("R7 read data", int'(rxByte), b);
      check("R7 nak on ninth clock", int'(capShift[0]), 1);
      check("R7 read pulses", riseCnt, 9);
      check("R7 lines after read", lines(), 2);
    end

    // R8 longer phases for write and read
    for (int L = 1; L < 4; L++) begin
      runCmd(4, 8'hA5 ^ L, L, 1, 0, 0, cyc);
      check("R8 write length", cyc, 19 * (L + 1));
      check("R8 write data", int'(capShift[8:1]), 8'hA5 ^ L);
      runCmd(5, 0, L, 3, 8'h5A ^ (L * 17), 0, cyc);
      check("R8 read length", cyc, 19 * (L + 1));
      check("R8 read data", int'(rxByte), 8'h5A ^ (L * 17));
    end

    // R9 request during a write is dropped
    keepRx = rxByte;
    runCmd(4, 8'h3C, 3, 1, 0, 1, cyc);
    check("R9 length unchanged by request", cyc, 19 * 4);
    check("R9 write data intact", int'(capShift[8:1]), 8'h3C);
    check("R9 rxByte untouched", int'(rxByte), int'(keepRx));
    @(negedge clk);
    check("R9 no second command", int'(busy), 0);

    // R4 stop
    runCmd(3, 0, 2, 0, 0, 0, cyc);
    check("R8 stop length", cyc, 3 * 3);
    check("R4 stop edge seen", stopCnt, 1);
    check("R4 lines after stop", lines(), 0);

    // R10 undefined codes
    foreach (keepRx[i]) if (i < 1) keepRx = rxByte;
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 6 || c == 7) begin
        @(negedge clk);
        cmdOp = c[2:0];
        cmdValid = 1'b1;
        @(negedge clk);
        cmdValid = 1'b0;
        check("R10 no busy for undefined code", int'(busy), 0);
        @(negedge clk);
        check("R10 lines unchanged", lines(), 0);
        check("R10 rxByte unchanged", int'(rxByte), int'(keepRx));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule